// File: doc/BRIEF.md
# Input-Clock DLL Lock Tracker

This block is a digital supervisor. It tracks whether the delay-locked loop of a DDR memory device would be locked. It runs on a free-running reference clock and samples the monitored input clock as data. It counts rising edges of the monitored clock and declares lock once a fixed number of consecutive, uninterrupted cycles has been seen.

It also times the interval since the last monitored edge, measured in reference ticks. A gap longer than a set threshold counts as a stopped or too-slow clock. Such a gap drops lock at once and restarts the count. The stall threshold therefore also acts as a crude minimum-frequency check.

A loop-enable pin turns the loop off. While the pin is low, the block reports bypass mode and never reports lock. When the pin is raised again, a full acquisition must be repeated.

Top module: `dll_lock_tracker`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `locked`=0, `bypass`=0 and `mode`=0.
- R2: `locked` rises only after LOCK_CYCLES (default 2048) monitored rising edges have been counted since the count last restarted. After LOCK_CYCLES-1 edges it is still 0.
- R3: While the count is in progress and the monitored clock is running, `mode`=0 (acquiring) and `locked`=0.
- R4: `mode` codes are 0 acquiring, 1 locked, 2 bypass and 3 halted. Halted is reported whenever the loop is enabled and the monitored clock is stalled, including after reset when the clock has never toggled.
- R5: A gap of up to STALL_TICKS (default 8) reference periods between monitored rising edges leaves lock and the count untouched.
- R6: A gap of more than STALL_TICKS reference periods does three things:
  - It clears `locked` one reference period after the threshold is reached, and `mode` shows 3 while the clock stays stopped.
  - It restarts the count.
  - The edge that ends the stall is counted as the first of the new sequence.
- R7: With `loop_on` low, `bypass`=1, `locked`=0 and `mode`=2 within three reference periods. This holds whether the monitored clock runs or stops.
- R8: When `loop_on` returns high, `bypass` clears and a full LOCK_CYCLES edges are needed again before `locked` rises.
- R9: Once locked, lock holds for as long as the monitored clock keeps running. The internal count never exceeds LOCK_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Monitored input clock, sampled as data |
| loop_on | input | 1 | High enables the loop, low selects bypass mode |
| locked | output | 1 | Lock flag |
| bypass | output | 1 | Loop is disabled |
| mode | output | 2 | 0 acquiring, 1 locked, 2 bypass, 3 halted |

## Verification
Suppose the edge count were wrong. Then `locked` would rise one or more monitored cycles early or late, so the bench samples exactly after edge LOCK_CYCLES-1 and after edge LOCK_CYCLES.

Suppose the idle timer were wrong. Then a stall of exactly STALL_TICKS+1 reference periods would fail to show, or a gap of exactly STALL_TICKS would wrongly drop lock. The loss appears within about two reference periods, and the bench exercises both sides of that boundary.

A wrong enable path shows up as `bypass` or `mode` failing to follow `loop_on` within three ticks, or as lock returning without a fresh full count.

// File: rtl/dll_trk_pkg.sv
package dll_trk_pkg;

  typedef enum logic [1:0] {
    MODE_ACQ  = 2'd0,
    MODE_LOCK = 2'd1,
    MODE_BYP  = 2'd2,
    MODE_HALT = 2'd3
  } trk_mode_e;

  // Mode priority: disabled loop first, then a stalled clock, then a full count.
  function automatic trk_mode_e pick_mode(input logic enabled, input logic stalled,
                                          input logic full);
    if (!enabled)     return MODE_BYP;
    else if (stalled) return MODE_HALT;
    else if (full)    return MODE_LOCK;
    else              return MODE_ACQ;
  endfunction

endpackage

// File: rtl/dll_edge_sync.sv
module dll_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], async_in};
  end

  // One-tick pulse when the synchronised level goes from low to high.
  assign rise_o = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

endmodule

// File: rtl/dll_stall_timer.sv
module dll_stall_timer #(
  parameter int STALL_TICKS = 8
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic stall_o
);

  localparam int IW = $clog2(STALL_TICKS + 1);
  localparam logic [IW-1:0] LIMIT = IW'(STALL_TICKS);

  logic [IW-1:0] idle_q;

  // Ticks since the last detected edge, saturating at the threshold.
  function automatic logic [IW-1:0] next_idle(input logic [IW-1:0] cur, input logic seen);
    if (seen)              return '0;
    else if (cur == LIMIT) return cur;
    else                   return cur + IW'(1);
  endfunction

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= next_idle(idle_q, edge_i);
  end

  assign stall_o = (idle_q == LIMIT);

endmodule

// File: rtl/dll_lock_counter.sv
module dll_lock_counter #(
  parameter int LOCK_CYCLES = 2048
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic edge_i,
  output logic full_o,
  output logic [$clog2(LOCK_CYCLES+1)-1:0] count_o
);

  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          full_q;

  // A clear and an edge in the same tick give a count of one.
  function automatic logic [CW-1:0] step(input logic [CW-1:0] cur, input logic clr,
                                         input logic hit);
    logic [CW-1:0] base;
    base = clr ? '0 : cur;
    if (hit && base != LIMIT) base = base + CW'(1);
    return base;
  endfunction

  assign cnt_d = step(cnt_q, clear_i, edge_i);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= (cnt_d == LIMIT);
    end
  end

  assign full_o  = full_q;
  assign count_o = cnt_q;

endmodule

// File: rtl/dll_lock_tracker.sv
module dll_lock_tracker
  import dll_trk_pkg::*;
#(
  parameter int LOCK_CYCLES = 2048,
  parameter int STALL_TICKS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       mon_clk,
  input  logic       loop_on,
  output logic       locked,
  output logic       bypass,
  output logic [1:0] mode
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  // Named internal events, visible to the bound checker.
  logic             edge_seen;
  logic             stall_now;
  logic             on_sync;
  logic             lock_full;
  logic             count_clear;
  logic [CNT_W-1:0] lock_count;

  logic [SYNC_STAGES-1:0] on_pipe;
  trk_mode_e              mode_q;

  // The enable pin synchroniser resets to "enabled", so no bypass is shown
  // during reset.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) on_pipe <= '1;
    else if (SYNC_STAGES > 1) on_pipe <= {on_pipe[SYNC_STAGES-2:0], loop_on};
    else on_pipe <= SYNC_STAGES'(loop_on);
  end
  assign on_sync = on_pipe[SYNC_STAGES-1];

  dll_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .async_in(mon_clk),
    .rise_o  (edge_seen)
  );

  dll_stall_timer #(.STALL_TICKS(STALL_TICKS)) u_stall (
    .ref_clk(ref_clk),
    .rst_n  (rst_n),
    .edge_i (edge_seen),
    .stall_o(stall_now)
  );

  assign count_clear = stall_now | ~on_sync;

  dll_lock_counter #(.LOCK_CYCLES(LOCK_CYCLES)) u_count (
    .ref_clk(ref_clk),
    .rst_n  (rst_n),
    .clear_i(count_clear),
    .edge_i (edge_seen),
    .full_o (lock_full),
    .count_o(lock_count)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_ACQ;
    else        mode_q <= pick_mode(on_sync, stall_now, lock_full);
  end

  assign mode   = mode_q;
  assign locked = (mode_q == MODE_LOCK);
  assign bypass = (mode_q == MODE_BYP);

endmodule

// File: rtl/dll_trk_chk.sv
module dll_trk_chk #(
  parameter int CNT_W       = 12,
  parameter int LOCK_CYCLES = 2048
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic             locked,
  input logic             bypass,
  input logic             on_sync,
  input logic             stall_now,
  input logic             lock_full,
  input logic [CNT_W-1:0] lock_count
);

  // R2
  lock_needs_full_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(locked) |-> $past(lock_full));

  // R6
  stall_drops_lock_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    stall_now |=> !locked);

  // R7
  bypass_follows_pin_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !on_sync |=> (bypass && !locked));

  // R7
  lock_bypass_excl_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(locked && bypass));

  // R9
  lock_holds_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (lock_full && !stall_now && on_sync) |=> locked);

  // R9
  no_overflow_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    lock_count <= CNT_W'(LOCK_CYCLES));

endmodule

bind dll_lock_tracker dll_trk_chk #(.CNT_W(CNT_W), .LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .ref_clk   (ref_clk),
  .rst_n     (rst_n),
  .locked    (locked),
  .bypass    (bypass),
  .on_sync   (on_sync),
  .stall_now (stall_now),
  .lock_full (lock_full),
  .lock_count(lock_count)
);

// File: tb/test_dll_lock_tracker.sv
module test_dll_lock_tracker;

  localparam int LOCKN = 2048;

  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic       mon_clk;
  logic       loop_on;
  logic       locked;
  logic       bypass;
  logic [1:0] mode;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    string      req;
    logic       lk;
    logic       bp;
    logic [1:0] md;
  } exp_t;

  exp_t sb_q[$];

  always #2 ref_clk = ~ref_clk;

  dll_lock_tracker i_dll_lock_tracker (
    .ref_clk(ref_clk),
    .rst_n  (rst_n),
    .mon_clk(mon_clk),
    .loop_on(loop_on),
    .locked (locked),
    .bypass (bypass),
    .mode   (mode)
  );

  // Driver side: queue an expectation just after a rising edge.
  task automatic expect_out(input string req, input logic lk, input logic bp,
                            input logic [1:0] md);
    exp_t e;
    e.req = req; e.lk = lk; e.bp = bp; e.md = md;
    @(posedge ref_clk); #1;
    sb_q.push_back(e);
  endtask

  // Each monitored cycle: high for 2 ticks, low for 2 + extra ticks.
  task automatic run_cycles(input int n, input int extra);
    for (int i = 0; i < n; i++) begin
      @(negedge ref_clk) mon_clk = 1'b1;
      @(negedge ref_clk);
      @(negedge ref_clk) mon_clk = 1'b0;
      @(negedge ref_clk);
      repeat (extra) @(negedge ref_clk);
    end
  endtask

  // Monitor side: compare on the falling edge.
  always @(negedge ref_clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (locked !== e.lk || bypass !== e.bp || mode !== e.md) begin
        failures++;
        $display("FAIL %s: locked=%b bypass=%b mode=%0d expected locked=%b bypass=%b mode=%0d",
                 e.req, locked, bypass, mode, e.lk, e.bp, e.md);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge ref_clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; loop_on = 1'b1; mon_clk = 1'b0;
    repeat (3) @(negedge ref_clk);
    expect_out("R1", 1'b0, 1'b0, 2'd0);
    @(negedge ref_clk) rst_n = 1'b1;
    // R4: the monitored clock has never toggled, so the block reports halted
    repeat (12) @(negedge ref_clk);
    expect_out("R4", 1'b0, 1'b0, 2'd3);
    // R3: mid-count
    run_cycles(1000, 0);
    expect_out("R3", 1'b0, 1'b0, 2'd0);
    // R2: one edge short, then exactly LOCKN
    run_cycles(LOCKN - 1 - 1000, 0);
    expect_out("R2", 1'b0, 1'b0, 2'd0);
    run_cycles(1, 0);
    expect_out("R2", 1'b1, 1'b0, 2'd1);
    // R5: gaps of exactly 8 ticks keep lock
    run_cycles(3, 4);
    expect_out("R5", 1'b1, 1'b0, 2'd1);
    // R9: lock persists on a steady clock
    run_cycles(200, 0);
    expect_out("R9", 1'b1, 1'b0, 2'd1);
    // R6: a gap of 9 ticks breaks lock; the resuming edge counts as the first
    run_cycles(1, 5);
    run_cycles(2, 0);
    expect_out("R6", 1'b0, 1'b0, 2'd0);
    run_cycles(LOCKN - 3, 0);
    expect_out("R6", 1'b0, 1'b0, 2'd0);
    run_cycles(1, 0);
    expect_out("R6", 1'b1, 1'b0, 2'd1);
    // R6: a long stop shows halted with lock cleared
    repeat (20) @(negedge ref_clk);
    expect_out("R6", 1'b0, 1'b0, 2'd3);
    // R7: disable while the clock runs, then while it is stopped
    @(negedge ref_clk) loop_on = 1'b0;
    run_cycles(5, 0);
    expect_out("R7", 1'b0, 1'b1, 2'd2);
    repeat (20) @(negedge ref_clk);
    expect_out("R7", 1'b0, 1'b1, 2'd2);
    // R8: re-enable requires a full count again
    @(negedge ref_clk) loop_on = 1'b1;
    repeat (2) @(negedge ref_clk);
    run_cycles(LOCKN - 1, 0);
    expect_out("R8", 1'b0, 1'b0, 2'd0);
    run_cycles(1, 0);
    expect_out("R8", 1'b1, 1'b0, 2'd1);
    // R1: reset while locked
    @(negedge ref_clk) rst_n = 1'b0;
    repeat (2) @(negedge ref_clk);
    expect_out("R1", 1'b0, 1'b0, 2'd0);
    @(negedge ref_clk) rst_n = 1'b1;
    expect_out("R1", 1'b0, 1'b0, 2'd0);
    repeat (3) @(negedge ref_clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule